// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master with Arbitration Loss Detection

This block is the controller side of a two-wire, open-drain serial bus (I2C). A host asks for one transfer at a time by giving a 7-bit target address, a direction and a byte count, and then pulsing a start strobe. The block generates the opening condition, shifts out the address with the direction bit, checks the target's acknowledge, and then writes or reads the requested bytes before closing the bus. Write bytes are taken from a data input, one byte per handshake pulse. Read bytes are presented on a data output with a one-cycle valid strobe.

The block never drives a line high. Its two outputs are pull-low enables, and a one is sent by letting the line float. Every bit the block owns is compared with the level seen on the wire while the clock line is high. If the block releases the data line and still sees it low, another controller has won the bus. The block then lets go of both lines at once and reports the loss. A bus monitor watches for opening and closing conditions made by other controllers, and a new transfer is held back while the bus belongs to someone else.

Top module: `i2c_arb_master`

## Requirements
- R1: Outside a transfer both pull-low enables are 0. A transfer begins with exactly one opening condition: the data line falls while the clock line is high.
- R2: The first byte carries the 7-bit address, most significant bit first, followed by the direction bit (1 = read, 0 = write). Each bit is valid while the clock line is high.
- R3: In a write, `count_i` data bytes are sent most significant bit first. Each byte is captured from `wdata_i` in the cycle before `wdata_take_o` pulses.
- R4: A released (high) acknowledge after the address or after a written byte sets `nack_o`. No further data byte is taken, and the bus is closed.
- R5: In a read, each byte is assembled most significant bit first and presented on `rdata_o` with a one-cycle `rdata_valid_o`. The block pulls the acknowledge low after every byte except the last, where it releases the line.
- R6: A transfer that is not lost ends with one closing condition, in which the data line rises while the clock line is high. `done_o` then pulses for one cycle, in the same cycle that `busy_o` falls.
- R7: Within a byte, the data enable changes only while the clock enable holds the clock line low.
- R8: If the block releases the data line for a bit it owns and samples it low, it lets go of both lines in the same cycle. It then sets `arb_lost_o` and pulses `done_o`, and it does not produce a closing condition.
- R9: After an opening condition from another controller, a requested transfer waits with both lines released until a closing condition is seen.
- R10: One clock-line period lasts 4*(`div_i`+1) system clock cycles, with `div_i` at least 2.
- R11: A `count_i` of 0 sends only the address byte and then closes the bus, taking no write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Quarter-bit length minus one, in system clocks |
| start_i | input | 1 | One-cycle request to begin a transfer; used only while idle |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | Direction: 1 = read, 0 = write |
| count_i | input | CNT_W | Number of data bytes |
| wdata_i | input | 8 | Next byte to write |
| wdata_take_o | output | 1 | Pulses after `wdata_i` has been captured |
| rdata_o | output | 8 | Last byte read |
| rdata_valid_o | output | 1 | One-cycle strobe for `rdata_o` |
| busy_o | output | 1 | Transfer requested or in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| nack_o | output | 1 | Acknowledge missing in the last transfer |
| arb_lost_o | output | 1 | Bus lost to another controller in the last transfer |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
A wrong bit counter or shift register shows within the same byte, as a wrong address or data value at the bus target or a wrong `rdata_o`. A wrong byte counter shows at the end of the transfer, as an extra or missing `wdata_take_o`, a misplaced read acknowledge, or a closing condition at the wrong time. A broken sample path or mismatch check shows within one bit time of the injected collision: the lines stay driven, or `arb_lost_o` stays low. A bad bus monitor shows as a transfer that starts on a busy bus or never starts at all.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_TX,
    ST_RX,
    ST_STOP
  } mst_state_e;

  // open drain: a zero is a pull, a one is a release
  function automatic logic pull_for(input logic b);
    return !b;
  endfunction

  // a bit the master let float but the wire reads low
  function automatic logic arb_mismatch(input logic released, input logic seen);
    return released && !seen;
  endfunction

  // master acknowledge after a read byte: pull unless it is the last
  function automatic logic rx_ack_pull(input logic last);
    return !last;
  endfunction
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic bus_busy
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_s, scl_d, sda_d;
  logic open_seen, close_seen;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end else begin
          scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
          sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  assign open_seen  = scl_s && scl_d && sda_d && !sda_s;
  assign close_seen = scl_s && scl_d && !sda_d && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (open_seen)       bus_busy <= 1'b1;
      else if (close_seen) bus_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master #(
  parameter int DIV_W       = 12,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [6:0]       addr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_take_o,
  output logic [7:0]       rdata_o,
  output logic             rdata_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             nack_o,
  output logic             arb_lost_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  import i2cm_pkg::*;

  localparam int BITS  = BYTE_BITS;
  localparam int ACK   = BITS;
  localparam int BCW   = $clog2(BITS + 1);

  mst_state_e           st;
  logic [1:0]           ph;
  logic [BCW-1:0]       bit_cnt;
  logic [BITS-1:0]      sh, rx;
  logic [CNT_W-1:0]     rem;
  logic                 is_addr, rd_r, ack_bad;
  logic                 tick, sda_s, bus_busy;

  // named internal events
  logic in_byte_w, wait_w, sample_w, advance_w, owned_bit_w, lost_w, last_rx_w;

  assign in_byte_w   = (st == ST_TX) || (st == ST_RX);
  assign wait_w      = (st == ST_WAIT);
  assign sample_w    = tick && in_byte_w && (ph == 2'd2);
  assign advance_w   = tick && in_byte_w && (ph == 2'd3);
  assign owned_bit_w = ((st == ST_TX) && (bit_cnt < BCW'(ACK))) ||
                       ((st == ST_RX) && (bit_cnt == BCW'(ACK)));
  assign lost_w      = sample_w && owned_bit_w && arb_mismatch(!sda_oe_o, sda_s);
  assign last_rx_w   = (rem == CNT_W'(1));
  assign busy_o      = (st != ST_IDLE);

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st != ST_IDLE && st != ST_WAIT),
    .div  (div_i),
    .tick (tick)
  );

  i2cm_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_s   (sda_s),
    .bus_busy(bus_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      ph            <= 2'd0;
      bit_cnt       <= '0;
      sh            <= '0;
      rx            <= '0;
      rem           <= '0;
      is_addr       <= 1'b0;
      rd_r          <= 1'b0;
      ack_bad       <= 1'b0;
      scl_oe_o      <= 1'b0;
      sda_oe_o      <= 1'b0;
      done_o        <= 1'b0;
      nack_o        <= 1'b0;
      arb_lost_o    <= 1'b0;
      wdata_take_o  <= 1'b0;
      rdata_valid_o <= 1'b0;
      rdata_o       <= '0;
    end else begin
      done_o        <= 1'b0;
      wdata_take_o  <= 1'b0;
      rdata_valid_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            sh         <= {addr_i, rd_i};
            rd_r       <= rd_i;
            rem        <= count_i;
            nack_o     <= 1'b0;
            arb_lost_o <= 1'b0;
            ph         <= 2'd0;
            st         <= bus_busy ? ST_WAIT : ST_START;
          end
        end
        ST_WAIT: begin
          if (!bus_busy) begin
            ph <= 2'd0;
            st <= ST_START;
          end
        end
        ST_START: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe_o <= 1'b1;
              2'd2: scl_oe_o <= 1'b1;
              2'd3: begin
                st       <= ST_TX;
                is_addr  <= 1'b1;
                bit_cnt  <= '0;
                sda_oe_o <= pull_for(sh[BITS-1]);
              end
              default: ;
            endcase
          end
        end
        ST_TX, ST_RX: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_oe_o <= 1'b0;
              2'd2: begin
                scl_oe_o <= 1'b1;
                if (st == ST_TX && bit_cnt == BCW'(ACK)) ack_bad <= sda_s;
                if (st == ST_RX && bit_cnt < BCW'(ACK))  rx <= {rx[BITS-2:0], sda_s};
                if (lost_w) begin
                  st         <= ST_IDLE;
                  ph         <= 2'd0;
                  scl_oe_o   <= 1'b0;
                  sda_oe_o   <= 1'b0;
                  arb_lost_o <= 1'b1;
                  done_o     <= 1'b1;
                end
              end
              2'd3: begin
                if (bit_cnt < BCW'(BITS - 1)) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (st == ST_TX) begin
                    sh       <= sh << 1;
                    sda_oe_o <= pull_for(sh[BITS-2]);
                  end else begin
                    sda_oe_o <= 1'b0;
                  end
                end else if (bit_cnt == BCW'(BITS - 1)) begin
                  bit_cnt <= BCW'(ACK);
                  if (st == ST_TX) begin
                    sda_oe_o <= 1'b0;
                  end else begin
                    sda_oe_o      <= rx_ack_pull(last_rx_w);
                    rdata_o       <= rx;
                    rdata_valid_o <= 1'b1;
                  end
                end else begin
                  bit_cnt <= '0;
                  if (st == ST_TX && ack_bad) begin
                    nack_o   <= 1'b1;
                    st       <= ST_STOP;
                    sda_oe_o <= 1'b1;
                  end else if (st == ST_TX && is_addr && rem == '0) begin
                    st       <= ST_STOP;
                    sda_oe_o <= 1'b1;
                  end else if (st == ST_TX && is_addr && rd_r) begin
                    st       <= ST_RX;
                    is_addr  <= 1'b0;
                    rx       <= '0;
                    sda_oe_o <= 1'b0;
                  end else if (st == ST_RX && !last_rx_w) begin
                    rem      <= rem - 1'b1;
                    rx       <= '0;
                    sda_oe_o <= 1'b0;
                  end else if (st == ST_TX && (is_addr || !last_rx_w)) begin
                    if (!is_addr) rem <= rem - 1'b1;
                    is_addr      <= 1'b0;
                    sh           <= wdata_i;
                    sda_oe_o     <= pull_for(wdata_i[BITS-1]);
                    wdata_take_o <= 1'b1;
                  end else begin
                    st       <= ST_STOP;
                    sda_oe_o <= 1'b1;
                  end
                end
              end
              default: ;
            endcase
          end
        end
        ST_STOP: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_oe_o <= 1'b0;
              2'd1: sda_oe_o <= 1'b0;
              2'd3: begin
                st     <= ST_IDLE;
                done_o <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic nack,
  input logic arb,
  input logic in_byte,
  input logic waiting,
  input logic rvalid,
  input logic rd_mode
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r7_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && !scl_oe && $past(in_byte && !scl_oe)) |-> $stable(sda_oe));

  a_r6_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (!scl_oe && !sda_oe && done));

  a_r4_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nack && arb));

  a_r9_wait_hands_off: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!scl_oe && !sda_oe));

  a_r5_valid_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rd_mode);
endmodule

bind i2c_arb_master i2cm_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_oe (scl_oe_o),
  .sda_oe (sda_oe_o),
  .busy   (busy_o),
  .done   (done_o),
  .nack   (nack_o),
  .arb    (arb_lost_o),
  .in_byte(in_byte_w),
  .waiting(wait_w),
  .rvalid (rdata_valid_o),
  .rd_mode(rd_r)
);

// File: tb/i2c_arb_master_bench.sv
`timescale 1ns/1ps
module i2c_arb_master_bench;
  localparam int DIV_W = 12;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div_i = 12'd4;
  logic start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic rd_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic [7:0] wdata_i;
  logic wdata_take_o, rdata_valid_o, busy_o, done_o, nack_o, arb_lost_o;
  logic [7:0] rdata_o;
  logic scl_oe_o, sda_oe_o;
  logic scl_w, sda_w;
  logic slv_pull = 1'b0;
  logic oth_pull = 1'b0;

  assign scl_w = !scl_oe_o;
  assign sda_w = !(sda_oe_o || slv_pull || oth_pull);

  always #10 clk = ~clk;

  i2c_arb_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_i2c_arb_master (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .start_i(start_i),
    .addr_i(addr_i), .rd_i(rd_i), .count_i(count_i), .wdata_i(wdata_i),
    .wdata_take_o(wdata_take_o), .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o),
    .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o), .arb_lost_o(arb_lost_o),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_src[$];
  logic [7:0] wbuf[8];
  int widx = 0, takes = 0, valids = 0, starts = 0, stops = 0;
  time t_prev = 0, t_last = 0;
  logic [6:0] s_addr = 7'h2A;
  int s_nack_at = -1, s_nwr = 0, s_nrd = 0;

  assign wdata_i = wbuf[widx[2:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_pop(input logic [7:0] got, input string req);
    if (exp_q.size() == 0) chk(1'b0, req, int'(got), -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(got == e, req, int'(got), int'(e));
    end
  endtask

  // bus event monitors
  always @(negedge sda_w) if (scl_w) starts++;
  always @(posedge sda_w) if (scl_w) stops++;
  always @(posedge scl_w) begin t_prev = t_last; t_last = $time; end

  // design-side monitor: take handshake and read results
  always @(negedge clk) if (rst_n) begin
    if (wdata_take_o) begin widx++; takes++; end
    if (rdata_valid_o) begin valids++; cmp_pop(rdata_o, "R5"); end
  end

  // bus target model
  initial begin : target
    logic [7:0] rxb, d;
    logic ack, m_ack;
    forever begin
      do @(negedge sda_w); while (!scl_w);
      rxb = '0;
      for (int i = 0; i < 8; i++) begin @(posedge scl_w); rxb = {rxb[6:0], sda_w}; end
      cmp_pop(rxb, "R2");
      ack = (rxb[7:1] == s_addr) && (s_nack_at != 0);
      @(negedge scl_w); slv_pull = ack; @(negedge scl_w); slv_pull = 1'b0;
      if (ack && rxb[0]) begin
        for (int k = 0; k < s_nrd; k++) begin
          d = (rd_src.size() != 0) ? rd_src.pop_front() : 8'h00;
          for (int i = 7; i >= 0; i--) begin slv_pull = !d[i]; @(negedge scl_w); end
          slv_pull = 1'b0;
          @(posedge scl_w); m_ack = !sda_w;
          chk(m_ack == (k != s_nrd - 1), "R5 master ack", int'(m_ack), int'(k != s_nrd - 1));
          @(negedge scl_w);
          if (!m_ack) break;
        end
      end else if (ack) begin
        for (int k = 1; k <= s_nwr; k++) begin
          rxb = '0;
          for (int i = 0; i < 8; i++) begin @(posedge scl_w); rxb = {rxb[6:0], sda_w}; end
          cmp_pop(rxb, "R3");
          ack = (k != s_nack_at);
          @(negedge scl_w); slv_pull = ack; @(negedge scl_w); slv_pull = 1'b0;
          if (!ack) break;
        end
      end
    end
  end

  // driver: queue expectations, then request the transfer
  task automatic drive(input logic [6:0] a, input logic r, input int n,
                       input int nack_at, input int n_exp_wr);
    s_nack_at = nack_at; s_nwr = n; s_nrd = r ? n : 0;
    exp_q.push_back({a, r});
    if (r) for (int i = 0; i < n; i++) begin
      rd_src.push_back(8'h5A ^ 8'(i * 37 + 1));
      exp_q.push_back(8'h5A ^ 8'(i * 37 + 1));
    end
    else for (int i = 0; i < n_exp_wr; i++) exp_q.push_back(wbuf[(widx + i) % 8]);
    @(negedge clk);
    addr_i = a; rd_i = r; count_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int c;
    c = 0;
    while (!done_o && c < 20000) begin @(negedge clk); c++; end
    chk(done_o == 1'b1, req, int'(done_o), 1);
  endtask

  int t0, s0, p0, v0;

  initial begin
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hC3 + i * 29);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe_o && !sda_oe_o, "R1 lines released", {scl_oe_o, sda_oe_o}, 0);
    chk(!busy_o && !done_o && !nack_o && !arb_lost_o, "R1 idle status",
        {busy_o, done_o, nack_o, arb_lost_o}, 0);

    // write of three bytes
    t0 = takes; s0 = starts; p0 = stops;
    drive(7'h2A, 1'b0, 3, -1, 3);
    wait_done("R6 write done");
    chk(!nack_o && !arb_lost_o, "R6 write status", {nack_o, arb_lost_o}, 0);
    chk(takes - t0 == 3, "R3 take count", takes - t0, 3);
    chk(starts - s0 == 1, "R1 one opening", starts - s0, 1);
    chk(stops - p0 == 1, "R6 one closing", stops - p0, 1);
    chk(int'(t_last - t_prev) == 4 * 5 * 20, "R10 period div4", int'(t_last - t_prev), 400);
    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
    @(negedge clk);
    chk(!busy_o && !done_o, "R6 single done", {busy_o, done_o}, 0);

    // read of two bytes
    v0 = valids; p0 = stops;
    drive(7'h2A, 1'b1, 2, -1, 0);
    wait_done("R5 read done");
    chk(valids - v0 == 2, "R5 valid count", valids - v0, 2);
    chk(stops - p0 == 1 && !nack_o, "R6 read close", stops - p0, 1);
    repeat (4) @(negedge clk);

    // address not acknowledged
    t0 = takes; p0 = stops;
    drive(7'h11, 1'b0, 2, -1, 0);
    wait_done("R4 addr nack done");
    chk(nack_o == 1'b1, "R4 addr nack flag", int'(nack_o), 1);
    chk(takes == t0, "R4 no take after addr nack", takes - t0, 0);
    chk(stops - p0 == 1, "R4 close after nack", stops - p0, 1);
    repeat (4) @(negedge clk);

    // second data byte not acknowledged
    t0 = takes;
    drive(7'h2A, 1'b0, 3, 2, 2);
    wait_done("R4 data nack done");
    chk(nack_o == 1'b1, "R4 data nack flag", int'(nack_o), 1);
    chk(takes - t0 == 2, "R4 stop taking", takes - t0, 2);
    chk(exp_q.size() == 0, "R4 bytes seen", exp_q.size(), 0);
    repeat (4) @(negedge clk);

    // address-only probe
    t0 = takes; p0 = stops;
    drive(7'h2A, 1'b0, 0, -1, 0);
    wait_done("R11 probe done");
    chk(takes == t0 && !nack_o, "R11 no data", takes - t0, 0);
    chk(stops - p0 == 1, "R11 closed", stops - p0, 1);
    repeat (4) @(negedge clk);

    // single read byte at the fastest divider
    div_i = 12'd2;
    v0 = valids;
    drive(7'h2A, 1'b1, 1, -1, 0);
    wait_done("R5 single read done");
    chk(valids - v0 == 1, "R5 single valid", valids - v0, 1);
    chk(int'(t_last - t_prev) == 4 * 3 * 20, "R10 period div2", int'(t_last - t_prev), 240);
    div_i = 12'd4;
    repeat (4) @(negedge clk);

    // bus owned by another controller
    s0 = starts; p0 = stops;
    oth_pull = 1'b1;
    repeat (20) @(negedge clk);
    drive(7'h2A, 1'b0, 1, -1, 1);
    repeat (100) @(negedge clk);
    chk(busy_o && !scl_oe_o && !sda_oe_o, "R9 held off",
        {busy_o, scl_oe_o, sda_oe_o}, 4);
    oth_pull = 1'b0;
    wait_done("R9 done after release");
    chk(!nack_o && !arb_lost_o, "R9 clean", {nack_o, arb_lost_o}, 0);
    chk(starts - s0 == 2 && stops - p0 == 2, "R9 bus events", starts - s0, 2);
    repeat (4) @(negedge clk);

    // collision on the first address bit
    s0 = starts; p0 = stops;
    fork
      begin
        wait (starts == s0 + 1);
        @(negedge scl_w);
        oth_pull = 1'b1;
      end
    join_none
    @(negedge clk);
    addr_i = 7'h50; rd_i = 1'b0; count_i = 1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R8 lost done");
    chk(arb_lost_o && !nack_o, "R8 lost flag", {arb_lost_o, nack_o}, 2);
    chk(!scl_oe_o && !sda_oe_o, "R8 lines released", {scl_oe_o, sda_oe_o}, 0);
    repeat (40) @(negedge clk);
    chk(stops == p0 && !scl_oe_o && !sda_oe_o, "R8 no closing", stops - p0, 0);
    oth_pull = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule